// File: doc/BRIEF.md
# Round-Robin Translation Lookaside Buffer

This block caches address translations for a 32-bit paged memory system. A lookup port takes a virtual address and, in the same cycle, reports whether any stored translation covers it. On a hit it also returns that translation's physical page base, permission bits, 4-bit domain and granularity code. The domain is returned so that the surrounding MMU can record the last domain it accessed.

Each slot holds a translation at one of three granularities: 4 KiB small page, 64 KiB large page or 1 MiB section. The address compare for a slot therefore uses the mask that belongs to that slot's own granularity code.

A table walker writes new translations through a fill port. A fill replaces the slot named by a single round-robin pointer, and the pointer then moves on. Two control inputs remove translations. One clears every slot. The other clears only the slots whose region contains a given virtual address. Fill and invalidate each take effect at the next clock edge.

Top module: `rr_tlb`

## Requirements
- R1: A synchronous active-low reset leaves every slot invalid, so that after reset no lookup hits.
- R2: The granularity code is 2 bits: 0 = invalid, 1 = small page, 2 = large page, 3 = section. A slot holding code 0 never matches a lookup.
- R3: The compare masks are as follows. A section keeps virtual address bits [31:20], a large page keeps [31:16] and a small page keeps [31:12]. The fill's virtual and physical addresses are stored after this mask, so a lookup anywhere inside the region hits and one just outside it misses.
- R4: On a hit, `lk_paddr` is the masked physical base, and `lk_perm`, `lk_domain` and `lk_map` are the slot's stored fields. On a miss, all four outputs are zero.
- R5: A fill overwrites the slot at the round-robin pointer, and the pointer then advances modulo ENTRIES. After ENTRIES further fills, the oldest of them is evicted and the rest stay resident.
- R6: `inv_all` makes every slot invalid from the next cycle. It has priority over a fill in the same cycle: that fill is dropped and the pointer does not move.
- R7: `inv_addr_en` clears only the slots whose region contains `inv_vaddr`. Slots covering other regions keep hitting.
- R8: When a fill and an address invalidate occur in the same cycle, the invalidate acts on the old contents and the fill is written afterwards. The new translation is therefore resident even if it covers `inv_vaddr`.
- R9: When several slots match one lookup, the slot with the lowest index supplies the outputs.
- R10: A fill with code 0 still uses up a slot and advances the pointer, but it creates no translation that can hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Some valid slot covers lk_vaddr |
| lk_paddr | output | 32 | Physical page base of the hitting slot |
| lk_perm | output | PERM_W | Permission bits of the hitting slot |
| lk_domain | output | DOM_W | Domain of the hitting slot |
| lk_map | output | 2 | Granularity code of the hitting slot |
| fill_en | input | 1 | Write a new translation |
| fill_vaddr | input | 32 | Virtual address of the new translation |
| fill_paddr | input | 32 | Physical address of the new translation |
| fill_perm | input | PERM_W | Permission bits to store |
| fill_domain | input | DOM_W | Domain to store |
| fill_map | input | 2 | Granularity code to store |
| inv_all | input | 1 | Invalidate every slot |
| inv_addr_en | input | 1 | Invalidate the slots covering inv_vaddr |
| inv_vaddr | input | 32 | Address for the selective invalidate |

## Verification
Several properties are checked on every cycle:
- A hit never reports code 0.
- A miss drives all data outputs to zero.
- No lookup hits in the cycle after reset or after `inv_all`.
- An address just filled with a nonzero code hits in the next cycle.
- An address just invalidated, without a fill in that cycle, misses in the next cycle.

Some behaviours only the directed scenarios can show:
- Region boundaries for each granularity.
- The round-robin eviction order after a full rotation.
- Lowest-index priority between overlapping slots.
- Survival of the slots that a selective invalidate leaves alone.

// File: rtl/tlb_pkg.sv
// Package tlb_pkg
// Shared granularity encoding and the per-granularity page mask.
// Assumes 32-bit virtual and physical addresses.
package tlb_pkg;

    localparam int ADDR_W    = 32;
    localparam int SMALL_LSB = 12;
    localparam int LARGE_LSB = 16;
    localparam int SECT_LSB  = 20;

    typedef enum logic [1:0] {
        MAP_NONE    = 2'd0,
        MAP_SMALL   = 2'd1,
        MAP_LARGE   = 2'd2,
        MAP_SECTION = 2'd3
    } tlb_map_e;

    // Mask that keeps only the page-base bits for a granularity code
    function automatic logic [ADDR_W-1:0] map_mask(input tlb_map_e m);
        logic [ADDR_W-1:0] ones;
        ones = '1;
        case (m)
            MAP_SMALL:   map_mask = ones << SMALL_LSB;
            MAP_LARGE:   map_mask = ones << LARGE_LSB;
            MAP_SECTION: map_mask = ones << SECT_LSB;
            default:     map_mask = '0;
        endcase
    endfunction

endpackage

// File: rtl/tlb_slot.sv
// Module tlb_slot
// One translation slot: it stores a masked virtual base, physical base,
// permission bits, domain and granularity code. It reports whether the
// lookup address and the invalidate address fall inside its region.
// Assumes write data arrive already masked. A write wins over a clear
// in the same cycle.
module tlb_slot
    import tlb_pkg::*;
#(
    parameter int PERM_W = 8,
    parameter int DOM_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_vbase,
    input  logic [ADDR_W-1:0] wr_pbase,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic [DOM_W-1:0]  wr_dom,
    input  tlb_map_e          wr_map,
    input  logic              clr,
    input  logic [ADDR_W-1:0] lk_vaddr,
    input  logic [ADDR_W-1:0] inv_vaddr,
    output logic              lk_match,
    output logic              inv_match,
    output logic [ADDR_W-1:0] rd_pbase,
    output logic [PERM_W-1:0] rd_perm,
    output logic [DOM_W-1:0]  rd_dom,
    output tlb_map_e          rd_map
);

    logic [ADDR_W-1:0] vbase_q;
    logic [ADDR_W-1:0] pbase_q;
    logic [PERM_W-1:0] perm_q;
    logic [DOM_W-1:0]  dom_q;
    tlb_map_e          map_q;
    logic [ADDR_W-1:0] own_mask;

    // Store a new translation, or drop validity on a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vbase_q <= '0;
            pbase_q <= '0;
            perm_q  <= '0;
            dom_q   <= '0;
            map_q   <= MAP_NONE;
        end else if (wr_en) begin
            vbase_q <= wr_vbase;
            pbase_q <= wr_pbase;
            perm_q  <= wr_perm;
            dom_q   <= wr_dom;
            map_q   <= wr_map;
        end else if (clr) begin
            map_q   <= MAP_NONE;
        end
    end

    // Region compare under this slot's own granularity mask
    always_comb begin
        own_mask  = map_mask(map_q);
        lk_match  = (map_q != MAP_NONE) && ((lk_vaddr & own_mask) == vbase_q);
        inv_match = (map_q != MAP_NONE) && ((inv_vaddr & own_mask) == vbase_q);
    end

    // Expose stored fields for the hit selector
    always_comb begin
        rd_pbase = pbase_q;
        rd_perm  = perm_q;
        rd_dom   = dom_q;
        rd_map   = map_q;
    end

endmodule

// File: rtl/tlb_rr_ptr.sv
// Module tlb_rr_ptr
// Round-robin victim pointer that advances by one per accepted fill and
// wraps at ENTRIES-1. Assumes ENTRIES >= 2.
module tlb_rr_ptr #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // Step the pointer modulo ENTRIES
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (advance)
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end

endmodule

// File: rtl/tlb_pick.sv
// Module tlb_pick
// Selects the lowest-index matching slot and drives the lookup outputs.
// All outputs are zero when no slot matches.
module tlb_pick
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PERM_W  = 8,
    parameter int DOM_W   = 4
) (
    input  logic [ENTRIES-1:0]             match,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] pbase,
    input  logic [ENTRIES-1:0][PERM_W-1:0] perm,
    input  logic [ENTRIES-1:0][DOM_W-1:0]  dom,
    input  logic [ENTRIES-1:0][1:0]        map,
    output logic                           hit,
    output logic [ADDR_W-1:0]              o_pbase,
    output logic [PERM_W-1:0]              o_perm,
    output logic [DOM_W-1:0]               o_dom,
    output logic [1:0]                     o_map
);

    // Scan from the top so that the lowest matching index wins
    always_comb begin
        hit     = |match;
        o_pbase = '0;
        o_perm  = '0;
        o_dom   = '0;
        o_map   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                o_pbase = pbase[i];
                o_perm  = perm[i];
                o_dom   = dom[i];
                o_map   = map[i];
            end
        end
    end

endmodule

// File: rtl/rr_tlb.sv
// Module rr_tlb
// Fully associative translation cache with mixed granularities.
// - Lookup is combinational.
// - Fill and invalidate act at the clock edge.
// - Victims are chosen by one round-robin pointer.
// - inv_all overrides a fill in the same cycle.
// - An address invalidate acts before a fill in the same cycle.
module rr_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PERM_W  = 8,
    parameter int DOM_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       lk_vaddr,
    output logic              lk_hit,
    output logic [31:0]       lk_paddr,
    output logic [PERM_W-1:0] lk_perm,
    output logic [DOM_W-1:0]  lk_domain,
    output logic [1:0]        lk_map,
    input  logic              fill_en,
    input  logic [31:0]       fill_vaddr,
    input  logic [31:0]       fill_paddr,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic [DOM_W-1:0]  fill_domain,
    input  logic [1:0]        fill_map,
    input  logic              inv_all,
    input  logic              inv_addr_en,
    input  logic [31:0]       inv_vaddr
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic                           fill_go;
    tlb_map_e                       fill_code;
    logic [ADDR_W-1:0]              fill_vbase;
    logic [ADDR_W-1:0]              fill_pbase;
    logic [IDX_W-1:0]               victim;
    logic [ENTRIES-1:0]             lk_match;
    logic [ENTRIES-1:0]             inv_match;
    logic [ENTRIES-1:0][ADDR_W-1:0] s_pbase;
    logic [ENTRIES-1:0][PERM_W-1:0] s_perm;
    logic [ENTRIES-1:0][DOM_W-1:0]  s_dom;
    logic [ENTRIES-1:0][1:0]        s_map;

    // Accept a fill unless a full invalidate claims the cycle; mask its addresses
    always_comb begin
        fill_go    = fill_en && !inv_all;
        fill_code  = tlb_map_e'(fill_map);
        fill_vbase = fill_vaddr & map_mask(fill_code);
        fill_pbase = fill_paddr & map_mask(fill_code);
    end

    tlb_rr_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (fill_go),
        .idx     (victim)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic     wr_here;
        logic     clr_here;
        tlb_map_e rd_map_e;

        // Route the fill to the victim slot and decode the clears
        always_comb begin
            wr_here  = fill_go && (victim == IDX_W'(g));
            clr_here = inv_all || (inv_addr_en && inv_match[g]);
        end

        tlb_slot #(.PERM_W(PERM_W), .DOM_W(DOM_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_here),
            .wr_vbase  (fill_vbase),
            .wr_pbase  (fill_pbase),
            .wr_perm   (fill_perm),
            .wr_dom    (fill_domain),
            .wr_map    (fill_code),
            .clr       (clr_here),
            .lk_vaddr  (lk_vaddr),
            .inv_vaddr (inv_vaddr),
            .lk_match  (lk_match[g]),
            .inv_match (inv_match[g]),
            .rd_pbase  (s_pbase[g]),
            .rd_perm   (s_perm[g]),
            .rd_dom    (s_dom[g]),
            .rd_map    (rd_map_e)
        );

        // Flatten the enum for the selector
        always_comb s_map[g] = rd_map_e;
    end

    tlb_pick #(.ENTRIES(ENTRIES), .PERM_W(PERM_W), .DOM_W(DOM_W)) u_pick (
        .match   (lk_match),
        .pbase   (s_pbase),
        .perm    (s_perm),
        .dom     (s_dom),
        .map     (s_map),
        .hit     (lk_hit),
        .o_pbase (lk_paddr),
        .o_perm  (lk_perm),
        .o_dom   (lk_domain),
        .o_map   (lk_map)
    );

endmodule

// File: rtl/tlb_checker.sv
// Module tlb_checker
// Cycle properties over the ports of rr_tlb, attached to it by bind.
module tlb_checker #(
    parameter int PERM_W = 8,
    parameter int DOM_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       lk_vaddr,
    input logic              lk_hit,
    input logic [31:0]       lk_paddr,
    input logic [PERM_W-1:0] lk_perm,
    input logic [DOM_W-1:0]  lk_domain,
    input logic [1:0]        lk_map,
    input logic              fill_en,
    input logic [31:0]       fill_vaddr,
    input logic [1:0]        fill_map,
    input logic              inv_all,
    input logic              inv_addr_en,
    input logic [31:0]       inv_vaddr
);

    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !lk_hit);

    assert_no_invalid_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_map != 2'd0);

    assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0 && lk_perm == '0 && lk_domain == '0 && lk_map == '0));

    assert_fill_resident_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fill_en && !inv_all && fill_map != 2'd0) && lk_vaddr == $past(fill_vaddr)) |-> lk_hit);

    assert_inv_all_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inv_all) |-> !lk_hit);

    assert_inv_addr_gone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inv_addr_en && !fill_en) && lk_vaddr == $past(inv_vaddr)) |-> !lk_hit);

endmodule

bind rr_tlb tlb_checker #(.PERM_W(PERM_W), .DOM_W(DOM_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_vaddr    (lk_vaddr),
    .lk_hit      (lk_hit),
    .lk_paddr    (lk_paddr),
    .lk_perm     (lk_perm),
    .lk_domain   (lk_domain),
    .lk_map      (lk_map),
    .fill_en     (fill_en),
    .fill_vaddr  (fill_vaddr),
    .fill_map    (fill_map),
    .inv_all     (inv_all),
    .inv_addr_en (inv_addr_en),
    .inv_vaddr   (inv_vaddr)
);

// File: tb/sim_rr_tlb.sv
module sim_rr_tlb;

    localparam int ENTRIES = 8;
    localparam int PERM_W  = 8;
    localparam int DOM_W   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       lk_vaddr = '0;
    logic              lk_hit;
    logic [31:0]       lk_paddr;
    logic [PERM_W-1:0] lk_perm;
    logic [DOM_W-1:0]  lk_domain;
    logic [1:0]        lk_map;
    logic              fill_en = 1'b0;
    logic [31:0]       fill_vaddr = '0;
    logic [31:0]       fill_paddr = '0;
    logic [PERM_W-1:0] fill_perm = '0;
    logic [DOM_W-1:0]  fill_domain = '0;
    logic [1:0]        fill_map = '0;
    logic              inv_all = 1'b0;
    logic              inv_addr_en = 1'b0;
    logic [31:0]       inv_vaddr = '0;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    rr_tlb #(.ENTRIES(ENTRIES), .PERM_W(PERM_W), .DOM_W(DOM_W)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit),
        .lk_paddr(lk_paddr), .lk_perm(lk_perm), .lk_domain(lk_domain),
        .lk_map(lk_map), .fill_en(fill_en), .fill_vaddr(fill_vaddr),
        .fill_paddr(fill_paddr), .fill_perm(fill_perm),
        .fill_domain(fill_domain), .fill_map(fill_map), .inv_all(inv_all),
        .inv_addr_en(inv_addr_en), .inv_vaddr(inv_vaddr)
    );

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_fill(input logic [31:0] va, input logic [31:0] pa,
                           input logic [7:0] pm, input logic [3:0] dm,
                           input logic [1:0] mp);
        @(negedge clk);
        fill_en = 1'b1; fill_vaddr = va; fill_paddr = pa;
        fill_perm = pm; fill_domain = dm; fill_map = mp;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    // Check the hit flag and, when a hit is expected, every output field
    task automatic look(input string tag, input logic [31:0] va, input logic eh,
                        input logic [31:0] ep, input logic [7:0] epm,
                        input logic [3:0] ed, input logic [1:0] em);
        lk_vaddr = va;
        #1;
        total++;
        if (lk_hit !== eh || lk_paddr !== ep || lk_perm !== epm ||
            lk_domain !== ed || lk_map !== em) begin
            bad++;
            $display("FAIL %s va=%h actual hit=%b pa=%h perm=%h dom=%h map=%0d expected hit=%b pa=%h perm=%h dom=%h map=%0d",
                     tag, va, lk_hit, lk_paddr, lk_perm, lk_domain, lk_map,
                     eh, ep, epm, ed, em);
        end
    endtask

    task automatic look_miss(input string tag, input logic [31:0] va);
        look(tag, va, 1'b0, 32'h0, 8'h0, 4'h0, 2'd0);
    endtask

    task automatic t_reset();
        look_miss("R1 reset empty", 32'h0000_0000);
        look_miss("R1 reset empty", 32'hFFFF_F000);
    endtask

    task automatic t_grains();
        do_fill(32'h1234_5678, 32'hABCD_EF01, 8'h5A, 4'd3, 2'd3);
        look("R3 section inside", 32'h123F_FFFF, 1'b1, 32'hABC0_0000, 8'h5A, 4'd3, 2'd3);
        look("R4 section base", 32'h1230_0000, 1'b1, 32'hABC0_0000, 8'h5A, 4'd3, 2'd3);
        look_miss("R3 section outside", 32'h1240_0000);
        do_fill(32'h4000_8000, 32'h7654_3210, 8'h33, 4'd5, 2'd2);
        look("R3 large inside", 32'h4000_FFFF, 1'b1, 32'h7654_0000, 8'h33, 4'd5, 2'd2);
        look_miss("R3 large outside", 32'h4001_0000);
        do_fill(32'h8000_3ABC, 32'h1357_9BDF, 8'hC3, 4'd9, 2'd1);
        look("R3 small inside", 32'h8000_3FFF, 1'b1, 32'h1357_9000, 8'hC3, 4'd9, 2'd1);
        look_miss("R3 small above", 32'h8000_4000);
        look_miss("R3 small below", 32'h8000_2FFF);
    endtask

    task automatic t_code_zero();
        do_fill(32'h0000_0000, 32'h5555_5555, 8'hFF, 4'hF, 2'd0);
        look_miss("R2 code zero no match", 32'h0000_0000);
        look_miss("R10 code zero no entry", 32'h0000_0FFF);
    endtask

    task automatic t_inv_addr();
        @(negedge clk);
        inv_addr_en = 1'b1; inv_vaddr = 32'h4000_1234;
        @(negedge clk);
        inv_addr_en = 1'b0;
        look_miss("R7 covered slot cleared", 32'h4000_8000);
        look("R7 section kept", 32'h1230_0004, 1'b1, 32'hABC0_0000, 8'h5A, 4'd3, 2'd3);
        look("R7 small kept", 32'h8000_3000, 1'b1, 32'h1357_9000, 8'hC3, 4'd9, 2'd1);
    endtask

    task automatic t_inv_all();
        @(negedge clk);
        inv_all = 1'b1;
        fill_en = 1'b1; fill_vaddr = 32'h9000_0000; fill_paddr = 32'h9000_0000;
        fill_perm = 8'h01; fill_domain = 4'd1; fill_map = 2'd3;
        @(negedge clk);
        inv_all = 1'b0; fill_en = 1'b0;
        look_miss("R6 fill dropped", 32'h9000_0000);
        look_miss("R6 section cleared", 32'h1230_0000);
        look_miss("R6 small cleared", 32'h8000_3000);
    endtask

    task automatic t_fill_and_inv();
        @(negedge clk);
        inv_addr_en = 1'b1; inv_vaddr = 32'hA000_5FFF;
        fill_en = 1'b1; fill_vaddr = 32'hA000_5000; fill_paddr = 32'h0002_4000;
        fill_perm = 8'h77; fill_domain = 4'd7; fill_map = 2'd1;
        @(negedge clk);
        inv_addr_en = 1'b0; fill_en = 1'b0;
        look("R8 fill after invalidate", 32'hA000_5FFF, 1'b1, 32'h0002_4000, 8'h77, 4'd7, 2'd1);
    endtask

    task automatic t_rotation();
        for (int i = 0; i < ENTRIES; i++)
            do_fill(32'hB000_0000 + (i << 12), 32'(i) << 12, 8'(i), 4'(i), 2'd1);
        for (int i = 0; i < ENTRIES; i++)
            look("R5 full table resident", 32'hB000_0000 + (i << 12), 1'b1,
                 32'(i) << 12, 8'(i), 4'(i), 2'd1);
        do_fill(32'hC000_0000, 32'hC000_0000, 8'hEE, 4'hE, 2'd3);
        look_miss("R5 oldest evicted", 32'hB000_0000);
        look("R5 second kept", 32'hB000_1000, 1'b1, 32'h0000_1000, 8'h01, 4'd1, 2'd1);
        look("R5 newest resident", 32'hC000_0000, 1'b1, 32'hC000_0000, 8'hEE, 4'hE, 2'd3);
    endtask

    task automatic t_reset_clears();
        do_reset();
        look_miss("R1 reset clears filled", 32'hB000_1000);
        look_miss("R1 reset clears filled", 32'hC000_0000);
    endtask

    task automatic t_priority();
        do_fill(32'hD000_1000, 32'h1111_1000, 8'h11, 4'd1, 2'd1);
        do_fill(32'hD000_0000, 32'h2220_0000, 8'h22, 4'd2, 2'd3);
        look("R9 lowest index wins", 32'hD000_1004, 1'b1, 32'h1111_1000, 8'h11, 4'd1, 2'd1);
        look("R9 single match", 32'hD000_2000, 1'b1, 32'h2220_0000, 8'h22, 4'd2, 2'd3);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_grains();
        t_code_zero();
        t_inv_addr();
        t_inv_all();
        t_fill_and_inv();
        t_rotation();
        t_reset_clears();
        t_priority();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule